// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write path of a parallel NOR flash and turns the stream of bus write cycles into single-cycle operation strobes. Each write presents an address and the low data byte. Every multi-cycle command starts with a fixed two-write unlock handshake and is followed by a code byte. Some commands have a second unlock handshake and a final code. When a sequence completes, the decoder raises exactly one strobe for one clock. The program strobe carries the target address and byte. The sector-erase strobe carries the sector address.

The decoder also holds an identification mode flag. While the flag is set, reads return a maker code, a part code and the boot-lock state. A separate engine runs the program and erase operations. That engine drives `busy`, and while `busy` is high every write is discarded.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset is released, the decoder waits for a fresh sequence, `id_mode` is 0 and every strobe is low.
- R2: Every multi-cycle command starts with 0xAA written to address 0x5555, followed by 0x55 written to address 0x2AAA. Only the low data byte is observed.
- R3: The handshake, then 0xA0 at 0x5555, then any fourth write, raises `prog_go` in the cycle after that fourth write. `prog_addr` and `prog_data` then hold that write's address and byte.
- R4: The handshake, 0x80 at 0x5555, the handshake again, then 0x10 at 0x5555 raises `chip_erase_go`.
- R5: The same first five writes followed by 0x30 at any address raise `sect_erase_go`, and `sect_addr` holds that sixth write's address.
- R6: The same first five writes followed by 0x40 at 0x5555 raise `lock_go`.
- R7: The handshake, then 0x90 at 0x5555, raises `id_enter_go` and sets `id_mode` at the same edge.
- R8: `id_exit_go` is raised and `id_mode` is cleared at the same edge by either of two forms. The first is the handshake followed by 0xF0 at 0x5555. The second is a single 0xF0 write that is not the expected next cycle of a sequence; this includes any 0xF0 write while waiting, at any address.
- R9: While `id_mode` is 1, `rd_data` is 0x1F for `rd_addr` 0, 0x82 for `rd_addr` 1, `{7'b0, boot_locked}` for `rd_addr` 2 and 0x00 for any other address. While `id_mode` is 0, `rd_data` is 0x00.
- R10: A write presented while `busy` is high produces no strobe and leaves the sequence position unchanged.
- R11: A write that is not the expected next cycle abandons the sequence. If that write is 0xAA at 0x5555, it counts as the first write of a new sequence.
- R12: Each strobe lasts exactly one cycle, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One write cycle is presented this clock |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Low data byte of the write |
| busy | input | 1 | A program or erase is running |
| boot_locked | input | 1 | Current boot-lock state |
| rd_addr | input | 17 | Read address for identification reads |
| rd_data | output | 8 | Identification data, zero outside identification mode |
| id_mode | output | 1 | Identification mode is active |
| prog_go | output | 1 | Word program strobe |
| prog_addr | output | 17 | Program target address |
| prog_data | output | 8 | Program data byte |
| chip_erase_go | output | 1 | Chip erase strobe |
| sect_erase_go | output | 1 | Sector erase strobe |
| sect_addr | output | 17 | Sector erase address |
| lock_go | output | 1 | Boot lockout enable strobe |
| id_enter_go | output | 1 | Identification entry strobe |
| id_exit_go | output | 1 | Identification exit strobe |

## Verification
The bench builds the decoder with its default parameters: a 17-bit address, unlock addresses 0x5555 and 0x2AAA, and codes 0x1F and 0x82. This makes the real command words and the identification reads reachable directly. Directed sequences cover every command. They also cover 0xF0 arriving at each position of a sequence, restart on 0xAA at 0x5555 mid-sequence, and 0xF0 used as program data. Long random runs then draw their writes mostly from the unlock and code values, so that partial and interleaved sequences are common.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERA3, ST_ERA4, ST_ERA5
  } seq_st_t;

  localparam logic [7:0] C_KEY_A  = 8'hAA;
  localparam logic [7:0] C_KEY_B  = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERASE  = 8'h80;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_LOCK   = 8'h40;
  localparam logic [7:0] C_ID_IN  = 8'h90;
  localparam logic [7:0] C_ID_OUT = 8'hF0;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic lock;
    logic id_in;
    logic id_out;
  } cmd_ev_t;
endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 17'h05555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 17'h02AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output cmd_ev_t           hit,
  output cmd_ev_t           ev,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  function automatic logic cyc_is(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                                  input logic [ADDR_W-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  seq_st_t st, st_nxt;
  logic take, restart, adv;

  assign take    = wr_en && !busy;
  assign restart = cyc_is(wr_addr, wr_data, KEY_ADDR_A, C_KEY_A);

  always_comb begin
    st_nxt = st;
    hit    = '0;
    adv    = 1'b0;
    if (take) begin
      case (st)
        ST_IDLE: if (restart) begin adv = 1'b1; st_nxt = ST_UNL1; end
        ST_UNL1: if (cyc_is(wr_addr, wr_data, KEY_ADDR_B, C_KEY_B)) begin
          adv = 1'b1; st_nxt = ST_UNL2;
        end
        ST_UNL2: if (wr_addr == KEY_ADDR_A) begin
          case (wr_data)
            C_PROG:   begin adv = 1'b1; st_nxt = ST_PROG; end
            C_ERASE:  begin adv = 1'b1; st_nxt = ST_ERA3; end
            C_ID_IN:  begin adv = 1'b1; st_nxt = ST_IDLE; hit.id_in = 1'b1; end
            C_ID_OUT: begin adv = 1'b1; st_nxt = ST_IDLE; hit.id_out = 1'b1; end
            default:  adv = 1'b0;
          endcase
        end
        ST_PROG: begin adv = 1'b1; st_nxt = ST_IDLE; hit.prog = 1'b1; end
        ST_ERA3: if (restart) begin adv = 1'b1; st_nxt = ST_ERA4; end
        ST_ERA4: if (cyc_is(wr_addr, wr_data, KEY_ADDR_B, C_KEY_B)) begin
          adv = 1'b1; st_nxt = ST_ERA5;
        end
        ST_ERA5: begin
          if (wr_data == C_SECT) begin
            adv = 1'b1; st_nxt = ST_IDLE; hit.sect = 1'b1;
          end else if (cyc_is(wr_addr, wr_data, KEY_ADDR_A, C_CHIP)) begin
            adv = 1'b1; st_nxt = ST_IDLE; hit.chip = 1'b1;
          end else if (cyc_is(wr_addr, wr_data, KEY_ADDR_A, C_LOCK)) begin
            adv = 1'b1; st_nxt = ST_IDLE; hit.lock = 1'b1;
          end
        end
        default: adv = 1'b0;
      endcase
      if (!adv) begin
        st_nxt     = restart ? ST_UNL1 : ST_IDLE;
        hit.id_out = !restart && (wr_data == C_ID_OUT);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ev      <= '0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      st <= st_nxt;
      ev <= hit;
      if (hit.prog || hit.sect) op_addr <= wr_addr;
      if (hit.prog) op_data <= wr_data;
    end
  end

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev));
  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> (ev == '0));
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(st));
  a_r3_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
    ev.prog |=> !ev.prog);
  a_r2_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UNL2) |-> ($past(st) == ST_UNL1 || $past(st) == ST_UNL2));
endmodule

// File: rtl/fcd_id_reg.sv
module fcd_id_reg #(
  parameter int ADDR_W = 17,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'h82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_id,
  input  logic              clr_id,
  input  logic              boot_locked,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_mode,
  output logic [7:0]        rd_data
);
  function automatic logic [7:0] id_lookup(input logic [ADDR_W-1:0] a, input logic lk);
    if (a == ADDR_W'(0)) return MFR_CODE;
    if (a == ADDR_W'(1)) return DEV_CODE;
    if (a == ADDR_W'(2)) return {7'b0, lk};
    return 8'h00;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      id_mode <= 1'b0;
    else if (set_id) id_mode <= 1'b1;
    else if (clr_id) id_mode <= 1'b0;
  end

  assign rd_data = id_mode ? id_lookup(rd_addr, boot_locked) : 8'h00;

  a_r7_enter_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_id |=> id_mode);
  a_r8_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_id |=> !id_mode);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 17'h05555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 17'h02AAA,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'h82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              boot_locked,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              id_mode,
  output logic              prog_go,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              chip_erase_go,
  output logic              sect_erase_go,
  output logic [ADDR_W-1:0] sect_addr,
  output logic              lock_go,
  output logic              id_enter_go,
  output logic              id_exit_go
);
  cmd_ev_t           hit, ev;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .hit(hit), .ev(ev), .op_addr(op_addr), .op_data(op_data)
  );

  fcd_id_reg #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk(clk), .rst_n(rst_n), .set_id(hit.id_in), .clr_id(hit.id_out),
    .boot_locked(boot_locked), .rd_addr(rd_addr), .id_mode(id_mode), .rd_data(rd_data)
  );

  assign prog_go       = ev.prog;
  assign chip_erase_go = ev.chip;
  assign sect_erase_go = ev.sect;
  assign lock_go       = ev.lock;
  assign id_enter_go   = ev.id_in;
  assign id_exit_go    = ev.id_out;
  assign prog_addr     = op_addr;
  assign sect_addr     = op_addr;
  assign prog_data     = op_data;

  a_r7_flag_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter_go |-> id_mode);
  a_r8_flag_off_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit_go |-> !id_mode);
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  logic        clk = 0, rst_n = 0, wr_en = 0, busy = 0, boot_locked = 0;
  logic [16:0] wr_addr = 0, rd_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rd_data;
  logic        id_mode, prog_go, chip_erase_go, sect_erase_go, lock_go, id_enter_go, id_exit_go;
  logic [16:0] prog_addr, sect_addr;
  logic [7:0]  prog_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder dut (.*);

  // reference model state
  int q_a[$], q_d[$];
  bit e_prog, e_chip, e_sect, e_lock, e_in, e_out, e_id;
  int e_paddr, e_pdata, e_saddr;

  function automatic bit m(int i, int a, int d);
    return q_a[i] == a && q_d[i] == d;
  endfunction

  // 0 broken, 1 partial, 2 prog, 3 chip, 4 sect, 5 lock, 6 id in, 7 id out
  function automatic int classify();
    int n = q_a.size();
    if (n >= 1 && !m(0, 'h5555, 'hAA)) return 0;
    if (n >= 2 && !m(1, 'h2AAA, 'h55)) return 0;
    if (n <= 2) return 1;
    if (q_a[2] != 'h5555) return 0;
    if (q_d[2] == 'hA0) return (n == 3) ? 1 : 2;
    if (q_d[2] == 'h90) return 6;
    if (q_d[2] == 'hF0) return 7;
    if (q_d[2] != 'h80) return 0;
    if (n == 3) return 1;
    if (!m(3, 'h5555, 'hAA)) return 0;
    if (n == 4) return 1;
    if (!m(4, 'h2AAA, 'h55)) return 0;
    if (n == 5) return 1;
    if (q_d[5] == 'h30) return 4;
    if (m(5, 'h5555, 'h10)) return 3;
    if (m(5, 'h5555, 'h40)) return 5;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    {e_prog, e_chip, e_sect, e_lock, e_in, e_out} = '0;
    if (!rst_n) begin
      q_a.delete(); q_d.delete(); e_id = 0;
    end else if (wr_en && !busy) begin
      int c;
      q_a.push_back(int'(wr_addr)); q_d.push_back(int'(wr_data));
      c = classify();
      if (c >= 2) begin
        case (c)
          2: begin e_prog = 1; e_paddr = wr_addr; e_pdata = wr_data; end
          3: e_chip = 1;
          4: begin e_sect = 1; e_saddr = wr_addr; end
          5: e_lock = 1;
          6: begin e_in = 1; e_id = 1; end
          default: begin e_out = 1; e_id = 0; end
        endcase
        q_a.delete(); q_d.delete();
      end else if (c == 0) begin
        q_a.delete(); q_d.delete();
        if (wr_addr == 'h5555 && wr_data == 'hAA) begin
          q_a.push_back('h5555); q_d.push_back('hAA);
        end else if (wr_data == 'hF0) begin
          e_out = 1; e_id = 0;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    if (!e_id) return 0;
    case (int'(rd_addr))
      0: return 'h1F;
      1: return 'h82;
      2: return boot_locked;
      default: return 0;
    endcase
  endfunction

  // compare on every falling edge
  always @(negedge clk) if (rst_n && !done) begin
    chk(prog_go == e_prog, "R3 prog_go", prog_go, e_prog);
    if (e_prog) begin
      chk(prog_addr == e_paddr, "R3 prog_addr", prog_addr, e_paddr);
      chk(prog_data == e_pdata, "R3 prog_data", prog_data, e_pdata);
    end
    chk(chip_erase_go == e_chip, "R4 chip_erase_go", chip_erase_go, e_chip);
    chk(sect_erase_go == e_sect, "R5 sect_erase_go", sect_erase_go, e_sect);
    if (e_sect) chk(sect_addr == e_saddr, "R5 sect_addr", sect_addr, e_saddr);
    chk(lock_go == e_lock, "R6 lock_go", lock_go, e_lock);
    chk(id_enter_go == e_in, "R7 id_enter_go", id_enter_go, e_in);
    chk(id_exit_go == e_out, "R8 id_exit_go", id_exit_go, e_out);
    chk(id_mode == e_id, "R9 id_mode", id_mode, e_id);
    chk(rd_data == exp_rd(), "R9 rd_data", rd_data, exp_rd());
    chk($countones({prog_go, chip_erase_go, sect_erase_go, lock_go, id_enter_go, id_exit_go}) <= 1,
        "R12 one strobe", 0, 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 17'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic keys();
    wr('h5555, 'hAA); wr('h2AAA, 'h55);
  endtask

  task automatic erase_head();
    keys(); wr('h5555, 'h80); keys();
  endtask

  // watchdog
  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(id_mode == 0, "R1 id_mode", id_mode, 0);
    chk({prog_go, chip_erase_go, sect_erase_go, lock_go, id_enter_go, id_exit_go} == 0,
        "R1 strobes", 0, 0);
    rst_n = 1;
    // R2 R3: program, including 0xF0 as data
    keys(); wr('h5555, 'hA0); wr('h01234, 'h5A);
    keys(); wr('h5555, 'hA0); wr('h1FFFF, 'hF0);
    // R4 R5 R6
    erase_head(); wr('h5555, 'h10);
    erase_head(); wr('h03123, 'h30);
    erase_head(); wr('h5555, 'h30);
    erase_head(); wr('h5555, 'h40);
    // R7 R9: ID reads with both lock states
    keys(); wr('h5555, 'h90);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rd_addr = 17'(i); boot_locked = i[0];
      @(negedge clk); boot_locked = ~boot_locked;
    end
    // R8: single-cycle exit, then long form
    wr('h00777, 'hF0);
    keys(); wr('h5555, 'h90); keys(); wr('h5555, 'hF0);
    // R8: 0xF0 mid-sequence
    keys(); wr('h5555, 'h90); wr('h5555, 'hAA); wr('h2AAA, 'hF0);
    // R11: restart inside sequences
    wr('h5555, 'hAA); wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'hA0); wr('h00010, 'h11);
    keys(); wr('h5555, 'h80); wr('h5555, 'hAA); wr('h5555, 'hAA); wr('h2AAA, 'h55);
    wr('h5555, 'hA0); wr('h00020, 'h22);
    keys(); wr('h4444, 'h12); wr('h5555, 'hA0);
    // R10: busy holds position and drops writes
    keys();
    busy = 1; wr('h5555, 'hA0); wr('h0FFFF, 'hF0); busy = 0;
    wr('h5555, 'hA0); wr('h00030, 'h33);
    // R1: reset mid-sequence
    keys(); wr('h5555, 'h80);
    @(negedge clk); rst_n = 0; @(negedge clk);
    chk(id_mode == 0, "R1 id_mode after reset", id_mode, 0);
    rst_n = 1;
    keys(); wr('h5555, 'hA0); wr('h00040, 'h44);
    // random traffic biased toward command values
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 15);
      int a, d;
      a = (r < 6) ? 'h5555 : (r < 11) ? 'h2AAA : int'($urandom_range(0, 'h1FFFF));
      case ($urandom_range(0, 10))
        0, 1, 2: d = 'hAA;
        3, 4: d = 'h55;
        5: d = 'h80;
        6: d = 'hA0;
        7: d = 'h90;
        8: d = 'hF0;
        9: d = ($urandom_range(0, 2) == 0) ? 'h10 : ($urandom_range(0, 1) ? 'h30 : 'h40);
        default: d = $urandom_range(0, 255);
      endcase
      @(negedge clk);
      busy = ($urandom_range(0, 9) == 0);
      rd_addr = 17'($urandom_range(0, 4));
      boot_locked = $urandom_range(0, 1);
      wr_en = ($urandom_range(0, 3) != 0);
      wr_addr = 17'(a); wr_data = 8'(d);
    end
    @(negedge clk); wr_en = 0; busy = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule